// File: doc/BRIEF.md
# Banked Address Mapper With Split Read/Write Blocks

This block sits between a 16-bit CPU address bus and a physical memory built from 16 KB blocks, up to 128 of them. The CPU space is cut into four 16 KB windows selected by the top two address bits. Each window has its own 8-bit mapping register that chooses which physical block the window reaches. The remaining 14 address bits pass through unchanged as the offset inside the block.

A mapping register works in one of two modes. In standard mode it names two of the eight standard blocks, one for reads and one for writes, so a copy loop can read one block and write another through the same window. In expansion mode it names a single block number for both directions. A separate force register can tie the read block of a standard-mode window to its write block without touching the mapping register. Expansion numbers that fall inside the installed internal memory always reach internal memory. Numbers above it go to external memory when that block is fitted. When it is not fitted, the number wraps onto an internal block, and how many low bits are kept depends on the installed memory size.

Software loads all five registers through a byte-wide I/O write port. The lookup itself is combinational, so the physical block follows the CPU address and the direction of the cycle at once.

Top module: `bank_mapper`

## Requirements
- R1: While reset is low, every mapping register and every force bit is cleared. After reset, reads and writes in all four windows give block 0 as an internal access.
- R2: An I/O write to address F0h, F1h, F2h or F3h loads the mapping register of window 0, 1, 2 or 3 (CPU address bits 15..14). A write to F4h loads the force register. A write to any other address changes nothing. A write is visible from the clock edge that captures it.
- R3: When bit 7 of a mapping register is 0 (standard mode), a read cycle (`cpu_wr`=0) uses bits 2..0 as the block and a write cycle (`cpu_wr`=1) uses bits 6..4. Bit 3 has no effect, and the access is internal.
- R4: Force register bit 6 serves window 0, bit 4 window 1, bit 5 window 2 and bit 7 window 3. When a standard-mode window's force bit is 1, reads use the write field (bits 6..4).
- R5: Force register bits 3..0 have no effect, and a force bit has no effect on a window in expansion mode.
- R6: When bit 7 of a mapping register is 1 (expansion mode), bits 6..0 form one expansion number that is used for both read and write cycles.
- R7: The internal block count is 8, 16 or 32 for `mem_size` 0, 1 or 2/3 (128, 256 or 512 KB). An expansion number below the count gives that block as an internal access, whatever `ext_present` is. This includes numbers 0..7, which reach the standard blocks.
- R8: An expansion number at or above the internal count, with `ext_present`=1, gives that number as the block with `ext_access`=1.
- R9: An expansion number at or above the internal count, with `ext_present`=0, gives its low 3, 4 or 5 bits (for `mem_size` 0, 1 or 2/3) as an internal access.
- R10: `phys_offset` equals CPU address bits 13..0. The outputs follow `cpu_addr`, `cpu_wr`, `mem_size` and `ext_present` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_en | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| mem_size | input | 2 | Installed internal memory: 0=128 KB, 1=256 KB, 2 or 3=512 KB |
| ext_present | input | 1 | Selected expansion block is fitted externally |
| cpu_addr | input | 16 | CPU memory address |
| cpu_wr | input | 1 | 1 for a write cycle, 0 for a read cycle |
| phys_block | output | 7 | Physical 16 KB block number |
| phys_offset | output | 14 | Byte offset inside the block |
| ext_access | output | 1 | 1 when the access goes to external memory |

## Verification
The bench builds the mapper with its default parameters: four windows, 7-bit block numbers, 14-bit offsets and an I/O base of F0h. With these values every installed memory size, each force-bit position and all three paths for an expansion number can be reached with single register writes. The vector table walks one register history through split reads and writes, the four force positions, and an alias case and a fitted-external case for each of the three memory sizes. Directed steps then cover the reset state, writes to addresses outside the register range, and expansion numbers below eight while `ext_present` is high.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    // width of one standard-block field inside a mapping register
    localparam int STD_W = 3;
    // mapping register width
    localparam int MAP_W = 8;

    // force-register bit that serves a given window; this order is fixed by software
    function automatic int frc_bit(input int win);
        case (win)
            0:       return 6;
            1:       return 4;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

    // log2 of the internal block count for a memory-size code
    function automatic int int_lg(input logic [1:0] size);
        case (size)
            2'd0:    return 3;
            2'd1:    return 4;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/map_regfile.sv
module map_regfile
    import mapper_pkg::*;
#(
    parameter int          NUM_WIN = 4,
    parameter logic [7:0]  IO_BASE = 8'hF0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [7:0]                     addr,
    input  logic [7:0]                     wdata,
    output logic [NUM_WIN-1:0][MAP_W-1:0]  map_o,
    output logic [NUM_WIN-1:0]             frc_o
);

    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        logic [NUM_WIN-1:0][MAP_W-1:0] map;
        logic [NUM_WIN-1:0]            frc;
    } regs_t;

    regs_t       regs_d, regs_q;
    logic [7:0]  rel;

    assign rel = addr - IO_BASE;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (rel < 8'(NUM_WIN)) begin
                regs_d.map[rel[IDX_W-1:0]] = wdata;
            end else if (rel == 8'(NUM_WIN)) begin
                for (int w = 0; w < NUM_WIN; w++) begin
                    regs_d.frc[w] = wdata[frc_bit(w)];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign map_o = regs_q.map;
    assign frc_o = regs_q.frc;

    // R1: registers are cleared while reset is held
    a_r1_cleared: assert property (@(posedge clk)
        !rst_n |-> (map_o == '0 && frc_o == '0));

    // R2: a write outside the register range leaves every register unchanged
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rel <= 8'(NUM_WIN)) |=> ($stable(map_o) && $stable(frc_o)));

endmodule

// File: rtl/window_decode.sv
module window_decode
    import mapper_pkg::*;
#(
    parameter int BLK_W = 7
) (
    input  logic [MAP_W-1:0]  map_i,
    input  logic              frc_i,
    input  logic [1:0]        mem_size,
    input  logic              ext_present,
    output logic [BLK_W-1:0]  rd_blk,
    output logic [BLK_W-1:0]  wr_blk,
    output logic              is_ext
);

    logic              exp_mode;
    logic [BLK_W-1:0]  num;
    logic [BLK_W-1:0]  mask;
    logic              fits_int;
    logic [STD_W-1:0]  std_rd, std_wr;

    assign exp_mode = map_i[MAP_W-1];
    assign num      = map_i[BLK_W-1:0];
    assign std_rd   = map_i[STD_W-1:0];
    assign std_wr   = map_i[2*STD_W:STD_W+1];
    assign mask     = BLK_W'((1 << int_lg(mem_size)) - 1);
    assign fits_int = (num & ~mask) == '0;

    always_comb begin
        if (exp_mode) begin
            is_ext = !fits_int && ext_present;
            if (fits_int || ext_present) rd_blk = num;
            else                         rd_blk = num & mask;
            wr_blk = rd_blk;
        end else begin
            is_ext = 1'b0;
            wr_blk = BLK_W'(std_wr);
            rd_blk = frc_i ? BLK_W'(std_wr) : BLK_W'(std_rd);
        end
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import mapper_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          OFF_W   = 14,
    parameter int          BLK_W   = 7,
    parameter logic [7:0]  IO_BASE = 8'hF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr_en,
    input  logic [7:0]         io_addr,
    input  logic [7:0]         io_wdata,
    input  logic [1:0]         mem_size,
    input  logic               ext_present,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_wr,
    output logic [BLK_W-1:0]   phys_block,
    output logic [OFF_W-1:0]   phys_offset,
    output logic               ext_access
);

    localparam int WIN_W   = ADDR_W - OFF_W;
    localparam int NUM_WIN = 1 << WIN_W;

    logic [NUM_WIN-1:0][MAP_W-1:0] map_q;
    logic [NUM_WIN-1:0]            frc_q;
    logic [BLK_W-1:0]              rd_blk [NUM_WIN];
    logic [BLK_W-1:0]              wr_blk [NUM_WIN];
    logic [NUM_WIN-1:0]            win_ext;
    logic [WIN_W-1:0]              win_sel;

    map_regfile #(
        .NUM_WIN (NUM_WIN),
        .IO_BASE (IO_BASE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (io_wr_en),
        .addr  (io_addr),
        .wdata (io_wdata),
        .map_o (map_q),
        .frc_o (frc_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        window_decode #(
            .BLK_W (BLK_W)
        ) u_dec (
            .map_i       (map_q[w]),
            .frc_i       (frc_q[w]),
            .mem_size    (mem_size),
            .ext_present (ext_present),
            .rd_blk      (rd_blk[w]),
            .wr_blk      (wr_blk[w]),
            .is_ext      (win_ext[w])
        );

        // R4: a forced standard-mode window reads and writes the same block
        a_r4_force_ties: assert property (@(posedge clk) disable iff (!rst_n)
            (!map_q[w][MAP_W-1] && frc_q[w]) |-> (rd_blk[w] == wr_blk[w]));

        // R6: expansion mode uses one block for both directions
        a_r6_exp_ties: assert property (@(posedge clk) disable iff (!rst_n)
            map_q[w][MAP_W-1] |-> (rd_blk[w] == wr_blk[w]));

        // R3: standard mode stays inside the eight standard blocks, internally
        a_r3_std_internal: assert property (@(posedge clk) disable iff (!rst_n)
            !map_q[w][MAP_W-1] |-> (rd_blk[w] < BLK_W'(8) && wr_blk[w] < BLK_W'(8) && !win_ext[w]));
    end

    assign win_sel     = cpu_addr[ADDR_W-1:OFF_W];
    assign phys_offset = cpu_addr[OFF_W-1:0];
    assign phys_block  = cpu_wr ? wr_blk[win_sel] : rd_blk[win_sel];
    assign ext_access  = win_ext[win_sel];

    // R8: an external access is only issued for a fitted block
    a_r8_ext_needs_present: assert property (@(posedge clk) disable iff (!rst_n)
        ext_access |-> ext_present);

    // R9: every internal access lands inside the installed memory
    a_r9_internal_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_access |-> (phys_block < BLK_W'(32)
                         && (mem_size != 2'd0 || phys_block < BLK_W'(8))
                         && (mem_size != 2'd1 || phys_block < BLK_W'(16))));

endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_en = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [1:0]  mem_size = 2'd0;
    logic        ext_present = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wr = 1'b0;
    logic [6:0]  phys_block;
    logic [13:0] phys_offset;
    logic        ext_access;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bank_mapper u_bank_mapper (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_wr_en    (io_wr_en),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .mem_size    (mem_size),
        .ext_present (ext_present),
        .cpu_addr    (cpu_addr),
        .cpu_wr      (cpu_wr),
        .phys_block  (phys_block),
        .phys_offset (phys_offset),
        .ext_access  (ext_access)
    );

    // {req, io addr, io data, mem_size, ext_present, cpu_addr, cpu_wr, exp block, exp ext}
    localparam int NV = 20;
    localparam logic [47:0] VEC [NV] = '{
        {4'd3, 8'hF0, 8'h52, 2'd0, 1'b0, 16'h0123, 1'b0, 7'd2,   1'b0}, // R3 split read
        {4'd3, 8'hF0, 8'h52, 2'd0, 1'b0, 16'h0123, 1'b1, 7'd5,   1'b0}, // R3 split write
        {4'd3, 8'hF1, 8'h3F, 2'd0, 1'b0, 16'h4000, 1'b0, 7'd7,   1'b0}, // R3 bit 3 ignored
        {4'd3, 8'hF1, 8'h3F, 2'd0, 1'b0, 16'h7FFF, 1'b1, 7'd3,   1'b0}, // R3 write field
        {4'd4, 8'hF4, 8'h10, 2'd0, 1'b0, 16'h4ABC, 1'b0, 7'd3,   1'b0}, // R4 bit 4 -> window 1
        {4'd4, 8'hF4, 8'h40, 2'd0, 1'b0, 16'h0010, 1'b0, 7'd5,   1'b0}, // R4 bit 6 -> window 0
        {4'd4, 8'hF4, 8'h40, 2'd0, 1'b0, 16'h4ABC, 1'b0, 7'd7,   1'b0}, // R4 window 1 released
        {4'd5, 8'hF4, 8'h0F, 2'd0, 1'b0, 16'h0010, 1'b0, 7'd2,   1'b0}, // R5 low force bits
        {4'd6, 8'hF2, 8'h85, 2'd0, 1'b0, 16'h8000, 1'b0, 7'd5,   1'b0}, // R6 exp read
        {4'd6, 8'hF2, 8'h85, 2'd0, 1'b0, 16'h8000, 1'b1, 7'd5,   1'b0}, // R6 exp write
        {4'd9, 8'hF2, 8'h8B, 2'd0, 1'b0, 16'h8000, 1'b0, 7'd3,   1'b0}, // R9 128K alias
        {4'd7, 8'hF2, 8'h8B, 2'd1, 1'b0, 16'h8000, 1'b1, 7'd11,  1'b0}, // R7 256K internal
        {4'd9, 8'hF2, 8'h9D, 2'd1, 1'b0, 16'hA000, 1'b0, 7'd13,  1'b0}, // R9 256K alias
        {4'd7, 8'hF2, 8'h9D, 2'd2, 1'b0, 16'hA000, 1'b0, 7'd29,  1'b0}, // R7 512K internal
        {4'd9, 8'hF2, 8'hCA, 2'd2, 1'b0, 16'hBFFF, 1'b0, 7'd10,  1'b0}, // R9 512K alias
        {4'd8, 8'hF2, 8'hCA, 2'd2, 1'b1, 16'hBFFF, 1'b1, 7'd74,  1'b1}, // R8 fitted external
        {4'd9, 8'hF3, 8'hFF, 2'd3, 1'b0, 16'hC000, 1'b0, 7'd31,  1'b0}, // R9 size code 3
        {4'd5, 8'hF4, 8'h20, 2'd0, 1'b1, 16'h8001, 1'b0, 7'd74,  1'b1}, // R5 force vs exp window
        {4'd2, 8'hF5, 8'h00, 2'd0, 1'b0, 16'h0000, 1'b0, 7'd2,   1'b0}, // R2 F5h ignored
        {4'd8, 8'hF3, 8'hFF, 2'd1, 1'b1, 16'hFFFF, 1'b1, 7'd127, 1'b1}  // R8 top block
    };

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp,
                         input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr_en = 1'b1;
        io_addr  = a;
        io_wdata = d;
        @(negedge clk);
        io_wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] sz, input logic ep, input logic [15:0] a,
                          input logic wr);
        mem_size    = sz;
        ext_present = ep;
        cpu_addr    = a;
        cpu_wr      = wr;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every window and direction maps to internal block 0
        for (int w = 0; w < 4; w++) begin
            for (int d = 0; d < 2; d++) begin
                lookup(2'd0, 1'b1, 16'(w << 14) | 16'h0155, d[0]);
                check(1, {9'd0, phys_block}, 16'd0, "reset block");
                check(1, {15'd0, ext_access}, 16'd0, "reset ext flag");
            end
        end

        // main table
        for (int i = 0; i < NV; i++) begin
            io_write(VEC[i][43:36], VEC[i][35:28]);
            lookup(VEC[i][27:26], VEC[i][25], VEC[i][24:9], VEC[i][8]);
            check(int'(VEC[i][47:44]), {9'd0, phys_block}, {9'd0, VEC[i][7:1]}, "block");
            check(int'(VEC[i][47:44]), {15'd0, ext_access}, {15'd0, VEC[i][0]}, "ext flag");
            check(10, {2'd0, phys_offset}, {2'd0, VEC[i][22:9]}, "offset R10");
        end

        // R7: expansion numbers 0..7 stay internal even with ext_present high
        for (int n = 0; n < 8; n++) begin
            io_write(8'hF1, 8'h80 | 8'(n));
            lookup(2'd2, 1'b1, 16'h5000, n[0]);
            check(7, {9'd0, phys_block}, 16'(n), "low expansion block");
            check(7, {15'd0, ext_access}, 16'd0, "low expansion internal");
        end

        // R2: write to an address below the range changes nothing
        io_write(8'h70, 8'hFF);
        lookup(2'd0, 1'b0, 16'h0000, 1'b0);
        check(2, {9'd0, phys_block}, 16'd2, "write to 70h ignored");

        // R2: write visible right after its capturing edge
        io_write(8'hF0, 8'h60);
        lookup(2'd0, 1'b0, 16'h0000, 1'b1);
        check(2, {9'd0, phys_block}, 16'd6, "new write field");

        // R10: same-cycle response to a change of direction
        cpu_wr = 1'b0;
        #1;
        check(10, {9'd0, phys_block}, 16'd0, "same-cycle read field");

        // R1: reset after activity clears the registers again
        do_reset();
        lookup(2'd0, 1'b1, 16'hC000, 1'b1);
        check(1, {9'd0, phys_block}, 16'd0, "reset after writes");
        check(1, {15'd0, ext_access}, 16'd0, "reset after writes ext");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule